// File: doc/BRIEF.md
# Serial Output-Level Setting Controller

This block receives commands over a three-wire serial link and keeps two 8-bit output-level codes. The link has a serial clock, a chip-select and a data input, plus a data output that is only driven while chip-select is high. Each channel holds two values. The live code drives the level output. The stored code models a non-volatile copy, which is reloaded into the live code at power-up and every time chip-select falls. A command can replace a live code for a trial setting, shift a live code back out on the data output, or copy a live code into its stored copy.

The block's clock is the serial clock, and it is assumed to run freely whenever a store is in progress. A command starts with a 1 bit. Next come a two-bit command code and a two-bit channel index, and then, for a write, eight data bits. Every field arrives least significant bit first. At least two idle clocks must follow each command before the next start bit is accepted. A store holds the ready output low for a programmable number of clocks, and commands sent during that time are dropped.

Top module: `sdac_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every live code and every stored code becomes `INIT_LEVEL` (default 8'h80) and `rdy` becomes 1, with no serial traffic needed.
- R2: While chip-select is high and the receiver is idle, 0 bits on `di` are discarded. A command begins at the first 1 bit sampled.
- R3: The command layout after the start bit is: code bit 0, code bit 1, channel bit 0, channel bit 1, then data bits 0 to 7 for a write. Code 1 (first code bit 1, second 0) writes the data into the live code. The new value shows on `levels` right after the edge that samples data bit 7. The live codes change at most one channel per clock.
- R4: Channel index 0 drives `levels[7:0]` and index 1 drives `levels[15:8]`. Indices 2 and 3 select nothing, so the command changes no code.
- R5: Code 0 (both code bits 0) is a read. After the edge that samples channel bit 1, `dout` shows bit i of the addressed live code during the clock that follows that edge plus i more edges, for i = 0 to 7. No code changes.
- R6: `dout_en` is high exactly while `cs` is high.
- R7: At every clock edge with `cs` low, each live code reloads from its stored code and any partly received command is discarded.
- R8: After the last bit of a command (data bit 7 for a write, bit 7 out for a read, channel bit 1 otherwise), the next two sampled bits are ignored. A 1 in either of them starts no command.
- R9: Code 2 (first code bit 0, second 1) to channel 0 or 1 captures that live code. It then holds `rdy` low for `STORE_CYC` clocks (default 16), starting right after the channel-bit-1 edge, and writes the stored code when `rdy` returns high.
- R10: A start bit sampled while `rdy` is low is ignored, so a whole command sent during a store has no effect.
- R11: A write changes only the live code. The stored code stays as it was, and the next `cs` low restores it.
- R12: Code 3 changes no code. After channel bit 1, the command ends and the idle gap follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cs | input | 1 | Chip-select, transfers enabled when high |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out, valid during reads |
| dout_en | output | 1 | Output enable for the data-out driver |
| rdy | output | 1 | High when idle, low while a store runs |
| levels | output | NCH*DW | Live codes, channel 0 in the low byte |

## Verification
A receiver that slips by one bit would show up on `levels` or `dout` at the end of the very command that follows, as a wrong byte or a byte on the wrong channel. A stored code that is wrong stays hidden until chip-select drops, so every store and every trial write is followed by a chip-select pulse that exposes the stored copy on `levels` within one clock. A busy counter that is off would lengthen or shorten the low pulse on `rdy`, or let a command through during a store, and either error shows on the same pins within the store window.

// File: rtl/sdac_pkg.sv
// Shared types for the serial level controller.
package sdac_pkg;
    typedef enum logic [2:0] {
        RX_IDLE, RX_CODE, RX_CHAN, RX_DATA, RX_READ, RX_GAP
    } rx_state_t;

    typedef enum logic [1:0] {
        CMD_READ  = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_STORE = 2'b10,
        CMD_NOP   = 2'b11
    } cmd_t;
endpackage

// File: rtl/sdac_rx.sv
// Command receiver. Hunts for the start bit, shifts the code, channel and data
// fields in LSB first, and pulses one strobe when a command completes.
// Assumes: clk is the serial clock; cs low aborts any command at once.
module sdac_rx
    import sdac_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 2,
    parameter int GAP_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          di,
    input  logic          busy,
    output logic          wr_stb,
    output logic          rd_stb,
    output logic          st_stb,
    output logic [AW-1:0] chan,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(DW + AW + GAP_CYC + 1);
    localparam logic [CW-1:0] LAST_DATA = CW'(DW - 1);
    localparam logic [CW-1:0] LAST_CHAN = CW'(AW - 1);
    localparam logic [CW-1:0] LAST_GAP  = CW'(GAP_CYC - 1);

    rx_state_t     st_q;
    logic [CW-1:0] cnt_q;
    cmd_t          cmd_q;
    logic [AW-1:0] chan_q;
    logic [DW-1:0] data_q;
    logic [AW-1:0] chan_nxt;
    logic          chan_done;

    assign chan_nxt  = {di, chan_q[AW-1:1]};
    assign chan_done = cs && (st_q == RX_CHAN) && (cnt_q == LAST_CHAN);

    // Strobes fire on the edge that samples the final bit of a command.
    assign rd_stb = chan_done && (cmd_q == CMD_READ);
    assign st_stb = chan_done && (cmd_q == CMD_STORE);
    assign wr_stb = cs && (st_q == RX_DATA) && (cnt_q == LAST_DATA);
    assign chan   = (st_q == RX_CHAN) ? chan_nxt : chan_q;
    assign data   = {di, data_q[DW-1:1]};

    // Frame sequencer: start hunt, field shifting, readout timing and gap.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            cmd_q  <= CMD_NOP;
            chan_q <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    if (di && !busy) st_q <= RX_CODE;
                end
                RX_CODE: begin
                    cmd_q <= cmd_t'({di, cmd_q[1]});
                    if (cnt_q == CW'(1)) begin
                        st_q  <= RX_CHAN;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_CHAN: begin
                    chan_q <= chan_nxt;
                    if (cnt_q == LAST_CHAN) begin
                        cnt_q <= '0;
                        case (cmd_q)
                            CMD_WRITE: st_q <= RX_DATA;
                            CMD_READ:  st_q <= RX_READ;
                            default:   st_q <= RX_GAP;
                        endcase
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    data_q <= data;
                    if (cnt_q == LAST_DATA) begin
                        st_q  <= RX_GAP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_READ: begin
                    if (cnt_q == LAST_DATA) begin
                        st_q  <= RX_GAP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == LAST_GAP) begin
                        st_q  <= RX_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sdac_bank.sv
// Level register bank. Holds a live and a stored code per channel, restores
// live from stored while cs is low, and runs the store busy window.
// Assumes: at most one strobe per clock; st_stb never arrives while busy.
module sdac_bank #(
    parameter int             NCH        = 2,
    parameter int             DW         = 8,
    parameter int             AW         = 2,
    parameter int             STORE_CYC  = 16,
    parameter logic [DW-1:0]  INIT_LEVEL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr_stb,
    input  logic              st_stb,
    input  logic [AW-1:0]     chan,
    input  logic [DW-1:0]     data,
    output logic [NCH*DW-1:0] levels,
    output logic [DW-1:0]     rd_word,
    output logic              busy
);
    localparam int BW = $clog2(STORE_CYC + 1);

    logic [DW-1:0] live_q   [NCH];
    logic [DW-1:0] stored_q [NCH];
    logic [BW-1:0] busy_q;
    logic [AW-1:0] pend_ch_q;
    logic [DW-1:0] pend_val_q;
    logic          chan_ok;
    logic          commit;

    assign chan_ok = int'(chan) < NCH;
    assign busy    = (busy_q != '0);
    assign commit  = (busy_q == BW'(1));

    // Selected live code, zero for an index with no channel behind it.
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NCH; c++) begin
            if (chan == AW'(c)) rd_word = live_q[c];
        end
    end

    // Busy window: load on a store strobe, count down to the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= '0;
            pend_ch_q  <= '0;
            pend_val_q <= '0;
        end else if (st_stb && chan_ok) begin
            busy_q     <= BW'(STORE_CYC);
            pend_ch_q  <= chan;
            pend_val_q <= rd_word;
        end else if (busy) begin
            busy_q <= busy_q - 1'b1;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Live code: restore while deselected, else take a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                             live_q[g] <= INIT_LEVEL;
            else if (!cs)                           live_q[g] <= stored_q[g];
            else if (wr_stb && chan == AW'(g))      live_q[g] <= data;
        end

        // Stored code: written only when the busy window closes.
        always_ff @(posedge clk) begin
            if (!rst_n)                             stored_q[g] <= INIT_LEVEL;
            else if (commit && pend_ch_q == AW'(g)) stored_q[g] <= pend_val_q;
        end

        assign levels[g*DW +: DW] = live_q[g];
    end
endmodule

// File: rtl/sdac_tx.sv
// Readout shifter. Loads the addressed code on a read strobe and presents one
// bit per clock, LSB first, on its output.
// Assumes: the receiver times the read window; bits outside it are unused.
module sdac_tx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] word,
    output logic          bit_o
);
    logic [DW-1:0] sh_q;

    // Load on strobe, otherwise shift toward bit 0 every clock.
    always_ff @(posedge clk) begin
        if (!rst_n)    sh_q <= '0;
        else if (load) sh_q <= word;
        else           sh_q <= {1'b0, sh_q[DW-1:1]};
    end

    assign bit_o = sh_q[0];
endmodule

// File: rtl/sdac_ctrl.sv
// Top of the serial level controller: receiver, level bank and readout.
// Assumes: clk is the serial clock and keeps running through a store.
module sdac_ctrl #(
    parameter int            NCH        = 2,
    parameter int            DW         = 8,
    parameter int            STORE_CYC  = 16,
    parameter logic [DW-1:0] INIT_LEVEL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              di,
    output logic              dout,
    output logic              dout_en,
    output logic              rdy,
    output logic [NCH*DW-1:0] levels
);
    localparam int AW = 2;

    logic          wr_stb, rd_stb, st_stb, busy;
    logic [AW-1:0] chan;
    logic [DW-1:0] data, rd_word;

    sdac_rx #(.DW(DW), .AW(AW), .GAP_CYC(2)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .busy(busy),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .st_stb(st_stb),
        .chan(chan), .data(data)
    );

    sdac_bank #(.NCH(NCH), .DW(DW), .AW(AW), .STORE_CYC(STORE_CYC),
                .INIT_LEVEL(INIT_LEVEL)) u_bank (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_stb(wr_stb), .st_stb(st_stb),
        .chan(chan), .data(data), .levels(levels), .rd_word(rd_word),
        .busy(busy)
    );

    sdac_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(rd_stb), .word(rd_word), .bit_o(dout)
    );

    assign dout_en = cs;
    assign rdy     = !busy;
endmodule

// File: rtl/sdac_ctrl_chk.sv
// Port-level checker for sdac_ctrl, attached by bind.
module sdac_ctrl_chk #(
    parameter int            NCH        = 2,
    parameter int            DW         = 8,
    parameter int            STORE_CYC  = 16,
    parameter logic [DW-1:0] INIT_LEVEL = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              rdy,
    input logic [NCH*DW-1:0] levels
);
    logic [NCH*DW-1:0] prev_q;
    logic [NCH-1:0]    chg;

    // Previous live codes, for per-channel change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= levels;
        else        prev_q <= levels;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chg
        assign chg[g] = levels[g*DW +: DW] != prev_q[g*DW +: DW];
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rdy && levels == {NCH{INIT_LEVEL}}));

    // R3
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs |=> $countones(chg) <= 1);

    // R10
    busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !rdy) |=> $stable(levels));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(cs));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (STORE_CYC > 1 && $fell(rdy)) |=> !rdy);
endmodule

bind sdac_ctrl sdac_ctrl_chk #(.NCH(NCH), .DW(DW), .STORE_CYC(STORE_CYC),
                               .INIT_LEVEL(INIT_LEVEL)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rdy(rdy), .levels(levels)
);

// File: tb/sdac_ctrl_test.sv
`timescale 1ns/1ps
module sdac_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic        di = 1'b0;
    logic        dout, dout_en, rdy;
    logic [15:0] levels;

    int checks = 0;
    int errors = 0;

    sdac_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .di(di),
        .dout(dout), .dout_en(dout_en), .rdy(rdy), .levels(levels)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_live [2];
    logic [7:0]  m_store [2];
    logic [7:0]  m_old [2];
    logic [11:0] m_bits;
    logic [7:0]  m_word;
    logic [7:0]  m_pend_v;
    logic        m_dout;
    int m_pos = -1, m_gap = 0, m_rd = -1, m_busy = 0, m_pend_c = 0;
    int m_bp, m_code, m_ch;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_live[0] = 8'h80; m_live[1] = 8'h80;
            m_store[0] = 8'h80; m_store[1] = 8'h80;
            m_pos = -1; m_gap = 0; m_rd = -1; m_busy = 0;
        end else begin
            m_bp = m_busy;
            m_old = m_store;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) m_store[m_pend_c] = m_pend_v;
            end
            if (!cs) begin
                m_live = m_old;
                m_pos = -1; m_gap = 0; m_rd = -1;
            end else if (m_gap > 0) begin
                m_gap--;
            end else if (m_rd >= 0) begin
                if (m_rd == 7) begin
                    m_rd = -1; m_gap = 2;
                end else begin
                    m_rd++; m_dout = m_word[m_rd];
                end
            end else if (m_pos < 0) begin
                if (di && m_bp == 0) m_pos = 0;
            end else begin
                m_bits[m_pos] = di;
                m_pos++;
                if (m_pos == 4) begin
                    m_code = int'(m_bits[1:0]);
                    m_ch = int'(m_bits[3:2]);
                    if (m_code == 0) begin
                        m_word = (m_ch < 2) ? m_live[m_ch] : 8'h00;
                        m_rd = 0; m_dout = m_word[0]; m_pos = -1;
                    end else if (m_code == 2) begin
                        if (m_ch < 2) begin
                            m_busy = 16; m_pend_c = m_ch; m_pend_v = m_live[m_ch];
                        end
                        m_pos = -1; m_gap = 2;
                    end else if (m_code == 3) begin
                        m_pos = -1; m_gap = 2;
                    end
                end else if (m_pos == 12) begin
                    if (m_ch < 2) m_live[m_ch] = m_bits[11:4];
                    m_pos = -1; m_gap = 2;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-clock comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 levels vs model", levels, {m_live[1], m_live[0]});
            chk("R9 rdy vs model", {15'd0, rdy}, {15'd0, (m_busy == 0)});
            chk("R6 dout_en", {15'd0, dout_en}, {15'd0, cs});
            if (cs && m_rd >= 0) chk("R5 dout vs model", {15'd0, dout}, {15'd0, m_dout});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            di = bits[i];
        end
    endtask

    task automatic idle(input int n);
        send(16'h0000, n);
    endtask

    task automatic cmd(input logic [1:0] code, input logic [1:0] ch,
                       input logic [7:0] val, input bit with_data);
        send({3'b000, val, ch, code, 1'b1}, with_data ? 13 : 5);
    endtask

    task automatic cs_pulse();
        @(negedge clk); #1;
        cs = 1'b0; di = 1'b0;
        chk("R6 dout_en low while deselected", {15'd0, dout_en}, 16'd0);
        @(negedge clk); #1;
        cs = 1'b1;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int lowcnt;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 reset level ch0", {8'd0, levels[7:0]}, 16'h0080);
        chk("R1 reset level ch1", {8'd0, levels[15:8]}, 16'h0080);
        chk("R1 reset rdy", {15'd0, rdy}, 16'd1);
        cs = 1'b1;
        idle(4);                         // R2: leading zeros discarded
        cmd(2'd1, 2'd0, 8'h3C, 1); idle(2);
        chk("R3 write ch0", levels, 16'h803C);
        cmd(2'd1, 2'd1, 8'hA5, 1); idle(2);
        chk("R4 write ch1 keeps ch0", levels, 16'hA53C);
        cmd(2'd1, 2'd2, 8'hFF, 1); idle(2);
        chk("R4 index 2 ignored", levels, 16'hA53C);
        cmd(2'd1, 2'd3, 8'h0F, 1); idle(2);
        chk("R4 index 3 ignored", levels, 16'hA53C);

        // R5: read channel 1, bits LSB first
        cmd(2'd0, 2'd1, 8'h00, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            di = 1'b0;
            chk("R5 read bit", {15'd0, dout}, {15'd0, 8'hA5 >> i & 1'b1});
        end
        idle(3);
        chk("R5 read leaves levels", levels, 16'hA53C);

        // R8: start bit on the second gap clock is ignored
        cmd(2'd1, 2'd0, 8'h11, 1);
        send(16'b0000_0000_0000_0010, 16);
        chk("R8 early start ignored", levels, 16'hA511);
        // R8: start on the first gap clock, then a full write
        cmd(2'd1, 2'd1, 8'h22, 1);
        send({3'b000, 8'hC3, 2'b00, 2'b01, 1'b1}, 13);
        idle(2);
        chk("R8 first-gap start ignored", levels[7:0], 8'h11);

        // R11 and R7: trial writes are lost on deselect
        cs_pulse();
        chk("R7 restore from stored", levels, 16'h8080);
        cmd(2'd1, 2'd0, 8'h55, 1);
        send({3'b000, 8'h66, 2'b00, 2'b01}, 6);
        cs_pulse();
        chk("R7 partial command discarded", levels, 16'h8080);
        idle(6);
        chk("R7 abandoned command no effect", levels, 16'h8080);

        // R9: store channel 1 and measure the busy window
        cmd(2'd1, 2'd1, 8'h77, 1); idle(2);
        cmd(2'd2, 2'd1, 8'h00, 0);
        lowcnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            di = 1'b0;
            if (!rdy) lowcnt++;
        end
        chk("R9 busy length", 16'(lowcnt), 16'd16);
        cmd(2'd1, 2'd1, 8'h12, 1); idle(2);
        chk("R11 trial write on ch1", levels[15:8], 8'h12);
        cs_pulse();
        chk("R9 stored value restored", levels, 16'h7780);

        // R10: command during store is dropped
        cmd(2'd1, 2'd0, 8'h9A, 1); idle(2);
        cmd(2'd2, 2'd0, 8'h00, 0); idle(2);
        cmd(2'd1, 2'd1, 8'hEE, 1); idle(2);
        chk("R10 write during busy ignored", levels, 16'h779A);
        idle(20);
        chk("R9 rdy back high", {15'd0, rdy}, 16'd1);
        cmd(2'd1, 2'd0, 8'h01, 1); idle(2);
        cs_pulse();
        chk("R9 store of ch0 committed", levels, 16'h779A);

        // R12: code 3 is a no-op
        cmd(2'd3, 2'd0, 8'h00, 0);
        send({3'b000, 8'h00, 2'b00, 2'b10, 1'b0}, 13);
        idle(4);
        chk("R12 code 3 no effect", levels, 16'h779A);

        // R9: store to an absent channel starts no busy window
        cmd(2'd2, 2'd2, 8'h00, 0);
        @(negedge clk); #1;
        chk("R9 absent channel no busy", {15'd0, rdy}, 16'd1);
        idle(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule